// File: doc/BRIEF.md
# Signed Restoring Sequential Divider

This block divides a signed dividend of twice the data width by a signed divisor of the data width. It produces a truncated quotient and a remainder, one quotient bit per clock. A request is presented with a single-cycle `start` pulse. The block then turns both operands into magnitudes and screens them for a zero divisor, for a quotient that cannot fit, and for a result that is trivially zero. Only then does it run the restoring loop. At the end it can round the quotient to the nearest value, and it re-applies the signs.

Results and flags are registered. They appear together with a one-cycle `done` pulse and stay unchanged until the next request finishes. While a request is in flight, `busy` is high and further `start` pulses have no effect.

Top module: `sdiv_restoring`

## Requirements
- R1: After reset, `busy`, `done`, `ovf` and `div0` are low and `quotient` and `remainder` are zero.
- R2: For a valid request, `remainder` is the magnitude of |dividend| mod |divisor|, given the dividend's sign. `quotient` is the low W bits of the signed quotient, truncated toward zero. Both are two's complement.
- R3: The quotient is negated when exactly one operand is negative, that is, when the XOR of the two sign bits is 1.
- R4: A zero divisor raises `div0` with `ovf` low and zero outputs, even when the overflow test would also hold.
- R5: When the upper W bits of |dividend| are at least |divisor| (and the divisor is non-zero), `ovf` is raised and both outputs are zero.
- R6: When the upper W bits of |dividend| are zero and the lower W bits are below |divisor|, the loop is skipped. The quotient magnitude is then 0 (before rounding) and the remainder magnitude is the lower W bits.
- R7: If `round_en` was high with `start`, the quotient magnitude is incremented when 2·|remainder| ≥ |divisor|. The remainder is not changed by rounding.
- R8: Counting the clock edge that samples `start` as edge 1, `done` is high after edge W+3 for a request that iterates. It is high after edge 3 for a zero divisor, an overflow or a skipped loop.
- R9: `done` is high for exactly one cycle, and the result outputs hold their values until the next request completes.
- R10: A `start` pulse while `busy` is high is ignored; the request in flight completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted only while idle |
| round_en | input | 1 | Enable round-to-nearest on the quotient for this request |
| dividend | input | 2W | Signed dividend |
| divisor | input | W | Signed divisor |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Signed quotient |
| remainder | output | W | Signed remainder |
| ovf | output | 1 | Quotient does not fit; outputs zeroed |
| div0 | output | 1 | Divisor was zero; outputs zeroed |

## Verification
The table walks every sign combination of dividend and divisor. This separates a quotient-sign fault from a remainder-sign fault, and each case is run with rounding both off and on at a remainder near half the divisor. Boundary operands cover several edges: the most negative divisor, an upper half exactly equal to the divisor (overflow) against one just below it, a zero divisor with a huge dividend (flag priority), and small dividends below the divisor (skipped loop). Each case's latency is measured at the ports, which separates the short screened path from the full W-step loop. Directed tests cover reset values, result hold after `done`, and a `start` issued mid-request.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOOP  = 2'd2,
    ST_FIN   = 2'd3
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_magnitude.sv
// Converts both signed operands to magnitude form and extracts their signs.
module sdiv_magnitude #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output logic           dvd_neg_o,
  output logic           dvs_neg_o
);
  always_comb begin
    dvd_neg_o = dvd_i[2*W-1];
    dvs_neg_o = dvs_i[W-1];
    dvd_mag_o = dvd_neg_o ? (~dvd_i + 1'b1) : dvd_i;
    dvs_mag_o = dvs_neg_o ? (~dvs_i + 1'b1) : dvs_i;
  end
endmodule

// File: rtl/sdiv_step.sv
// One restoring iteration: shift the pair left, trial-subtract, keep or restore.
module sdiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         negative;

  always_comb begin
    shifted  = {acc_i, quo_i[W-1]};
    trial    = {1'b0, shifted} - {2'b00, dvs_i};
    negative = trial[W+1];
    acc_o    = negative ? shifted[W-1:0] : trial[W-1:0];
    quo_o    = {quo_i[W-2:0], ~negative};
  end
endmodule

// File: rtl/sdiv_finish.sv
// Optional round-to-nearest on the quotient magnitude, then sign restoration.
module sdiv_finish #(
  parameter int W = 16
) (
  input  logic [W-1:0] qmag_i,
  input  logic [W-1:0] rmag_i,
  input  logic [W-1:0] dvs_mag_i,
  input  logic         qneg_i,
  input  logic         rneg_i,
  input  logic         round_i,
  input  logic         exc_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic         bump;
  logic [W-1:0] qr;

  always_comb begin
    bump = round_i && ({rmag_i, 1'b0} >= {1'b0, dvs_mag_i});
    qr   = qmag_i + {{(W-1){1'b0}}, bump};
    if (exc_i) begin
      quo_o = '0;
      rem_o = '0;
    end else begin
      quo_o = qneg_i ? (~qr + 1'b1) : qr;
      rem_o = rneg_i ? (~rmag_i + 1'b1) : rmag_i;
    end
  end
endmodule

// File: rtl/sdiv_restoring.sv
module sdiv_restoring
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           round_en,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           ovf,
  output logic           div0
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  sdiv_state_e st_q, st_d;
  logic [W-1:0]  acc_q, acc_d, quo_q, quo_d, dvs_q, dvs_d;
  logic          qneg_q, qneg_d, rneg_q, rneg_d, rnd_q, rnd_d;
  logic          eovf_q, eovf_d, edz_q, edz_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  quo_out_q, rem_out_q;
  logic          ovf_out_q, dz_out_q, done_q;
  logic          out_en, done_d;

  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           dvd_neg, dvs_neg;
  logic [W-1:0]   step_acc, step_quo;
  logic [W-1:0]   fin_quo, fin_rem;

  sdiv_magnitude #(.W(W)) u_mag (
    .dvd_i(dividend), .dvs_i(divisor),
    .dvd_mag_o(dvd_mag), .dvs_mag_o(dvs_mag),
    .dvd_neg_o(dvd_neg), .dvs_neg_o(dvs_neg)
  );

  sdiv_step #(.W(W)) u_step (
    .acc_i(acc_q), .quo_i(quo_q), .dvs_i(dvs_q),
    .acc_o(step_acc), .quo_o(step_quo)
  );

  sdiv_finish #(.W(W)) u_fin (
    .qmag_i(quo_q), .rmag_i(acc_q), .dvs_mag_i(dvs_q),
    .qneg_i(qneg_q), .rneg_i(rneg_q), .round_i(rnd_q),
    .exc_i(eovf_q | edz_q),
    .quo_o(fin_quo), .rem_o(fin_rem)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    acc_d  = acc_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    rnd_d  = rnd_q;
    eovf_d = eovf_q;
    edz_d  = edz_q;
    cnt_d  = cnt_q;
    out_en = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          acc_d  = dvd_mag[2*W-1:W];
          quo_d  = dvd_mag[W-1:0];
          dvs_d  = dvs_mag;
          qneg_d = dvd_neg ^ dvs_neg;
          rneg_d = dvd_neg;
          rnd_d  = round_en;
          eovf_d = 1'b0;
          edz_d  = 1'b0;
          cnt_d  = '0;
          st_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (dvs_q == '0) begin
          edz_d = 1'b1;
          st_d  = ST_FIN;
        end else if (acc_q >= dvs_q) begin
          eovf_d = 1'b1;
          st_d   = ST_FIN;
        end else if ((acc_q == '0) && (quo_q < dvs_q)) begin
          acc_d = quo_q;
          quo_d = '0;
          st_d  = ST_FIN;
        end else begin
          st_d = ST_LOOP;
        end
      end
      ST_LOOP: begin
        acc_d = step_acc;
        quo_d = step_quo;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_FIN;
      end
      ST_FIN: begin
        out_en = 1'b1;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q      <= ST_IDLE;
      acc_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      qneg_q    <= 1'b0;
      rneg_q    <= 1'b0;
      rnd_q     <= 1'b0;
      eovf_q    <= 1'b0;
      edz_q     <= 1'b0;
      cnt_q     <= '0;
      quo_out_q <= '0;
      rem_out_q <= '0;
      ovf_out_q <= 1'b0;
      dz_out_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      acc_q  <= acc_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
      rnd_q  <= rnd_d;
      eovf_q <= eovf_d;
      edz_q  <= edz_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (out_en) begin
        quo_out_q <= fin_quo;
        rem_out_q <= fin_rem;
        ovf_out_q <= eovf_q;
        dz_out_q  <= edz_q;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_out_q;
  assign remainder = rem_out_q;
  assign ovf       = ovf_out_q;
  assign div0      = dz_out_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done);

  // R4: zero-divisor result carries zero outputs and no overflow
  a_r4_div0_zero: assert property (@(posedge clk) disable iff (!rs_n)
    (done && div0) |-> (quotient == '0 && remainder == '0 && !ovf));

  // R5: overflow result carries zero outputs
  a_r5_ovf_zero: assert property (@(posedge clk) disable iff (!rs_n)
    (done && ovf) |-> (quotient == '0 && remainder == '0));

  // R10: operands in flight are not disturbed by a new start
  a_r10_operands_hold: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q == ST_LOOP) |=> ($stable(dvs_q) && $stable(qneg_q) && $stable(rnd_q)));

  // R9: outputs change only on the cycle done rises
  a_r9_output_hold: assert property (@(posedge clk) disable iff (!rs_n)
    !done |-> ($stable(quotient) && $stable(remainder)) or $rose(done));
endmodule

// File: tb/tb_sdiv_restoring.sv
module tb_sdiv_restoring;
  localparam int W = 16;
  localparam int NV = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           round_en = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic           busy, done, ovf, div0;
  logic [W-1:0]   quotient, remainder;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sdiv_restoring #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .round_en(round_en),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .ovf(ovf), .div0(div0)
  );

  // {round, dividend, divisor, expected path: 0 loop, 1 short, 2 ovf, 3 div0}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 32'h0000_0064, 16'h0007, 2'd0},
    {1'b0, 32'hFFFF_FF9C, 16'h0007, 2'd0},
    {1'b1, 32'h0000_0064, 16'hFFF9, 2'd0},
    {1'b1, 32'hFFFF_FF9C, 16'hFFF9, 2'd0},
    {1'b1, 32'h0000_03E8, 16'h0007, 2'd0},
    {1'b0, 32'h0000_03E8, 16'h0007, 2'd0},
    {1'b1, 32'h0000_0005, 16'h0009, 2'd1},
    {1'b0, 32'h0000_0005, 16'h0009, 2'd1},
    {1'b0, 32'h0001_0000, 16'h0001, 2'd2},
    {1'b0, 32'h0000_FFFF, 16'h0001, 2'd0},
    {1'b0, 32'h7FFF_FFFF, 16'h0000, 2'd3},
    {1'b0, 32'h7FFF_0000, 16'h8000, 2'd0},
    {1'b0, 32'h8000_0000, 16'h8000, 2'd2},
    {1'b0, 32'h0000_0000, 16'h0005, 2'd1},
    {1'b1, 32'h075B_CD15, 16'h3039, 2'd0},
    {1'b0, 32'hFFFF_FFFF, 16'h0001, 2'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent reference from the requirements
  task automatic model(input logic [2*W-1:0] dvd, input logic [W-1:0] dvs, input bit rnd,
                       output logic [W-1:0] eq, output logic [W-1:0] er,
                       output bit eovf, output bit edz, output int elat);
    longint d, v, dm, vm, qm, rm;
    d = longint'($signed(dvd));
    v = longint'($signed(dvs));
    dm = (d < 0) ? -d : d;
    vm = (v < 0) ? -v : v;
    eovf = 0; edz = 0; eq = '0; er = '0; elat = W + 3;
    if (vm == 0) begin
      edz = 1; elat = 3;
    end else if ((dm >> W) >= vm) begin
      eovf = 1; elat = 3;
    end else begin
      if ((dm >> W) == 0 && (dm % (64'd1 << W)) < vm) elat = 3;
      qm = dm / vm;
      rm = dm % vm;
      if (rnd && 2 * rm >= vm) qm++;
      eq = W'(((d < 0) != (v < 0)) ? -qm : qm);
      er = W'((d < 0) ? -rm : rm);
    end
  endtask

  task automatic run(input logic [2*W-1:0] dvd, input logic [W-1:0] dvs, input bit rnd,
                     output int lat);
    @(negedge clk);
    dividend = dvd; divisor = dvs; round_en = rnd; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] eq, er;
    bit eovf, edz;
    int elat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !ovf && !div0, "R1", "reset flags",
          {busy, done, ovf, div0}, 0);
    check(quotient == '0 && remainder == '0, "R1", "reset outputs",
          {quotient, remainder}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [2*W-1:0] vd;
      logic [W-1:0] vs;
      bit vr;
      logic [1:0] path;
      {vr, vd, vs, path} = VEC[i];
      model(vd, vs, vr, eq, er, eovf, edz, elat);
      run(vd, vs, vr, lat);
      check(quotient == eq, "R2/R3/R7", $sformatf("vec %0d quotient", i), quotient, eq);
      check(remainder == er, "R2/R6", $sformatf("vec %0d remainder", i), remainder, er);
      check(ovf == eovf && (path == 2'd2) == eovf, "R5", $sformatf("vec %0d ovf", i), ovf, eovf);
      check(div0 == edz && (path == 2'd3) == edz, "R4", $sformatf("vec %0d div0", i), div0, edz);
      check(lat == elat && (path == 2'd0) == (elat == W + 3), "R8",
            $sformatf("vec %0d latency", i), lat, elat);
    end

    // R9: done lasts one cycle, outputs hold afterwards
    run(32'h0000_0064, 16'h0007, 1'b0, lat);
    @(negedge clk);
    check(!done, "R9", "done pulse width", done, 0);
    repeat (5) @(negedge clk);
    check(quotient == 16'd14 && remainder == 16'd2, "R9", "hold after done",
          {quotient, remainder}, {16'd14, 16'd2});

    // R10: start during busy is ignored
    @(negedge clk);
    dividend = 32'h0000_03E8; divisor = 16'h0007; round_en = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 32'hFFFF_FF9C; divisor = 16'h0003; round_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(quotient == 16'd142 && remainder == 16'd6, "R10", "mid-flight start ignored",
          {quotient, remainder}, {16'd142, 16'd6});
    repeat (3) @(negedge clk);
    check(!busy && !done, "R10", "no second request", {busy, done}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule